// File: doc/BRIEF.md
# Synchronous Burst SRAM with Byte-Lane Writes

This block models a single-port synchronous static memory. Its word is made of byte lanes (four lanes of nine bits by default), and its depth is a parameter kept small for simulation. Every input except the output enable is sampled on the rising clock edge. An access starts when an address strobe is seen while the chip is selected. The low two address bits then seed a burst counter, and the advance input steps that counter through an aligned group of four words.

A controller state machine has three states. `ST_IDLE` is deselected and nothing is driven. `ST_READ` means the last access was a read. `ST_WRITE` means the last access was a write. The transitions are:
- `LOAD` is a strobe while selected. It goes to `ST_READ` or `ST_WRITE` according to the write controls.
- `CONT` is a cycle with no strobe while a burst is open. It steps or holds the address and goes to `ST_READ` or `ST_WRITE`.
- `DESEL` is a strobe while not selected. It goes to `ST_IDLE`.
- `STAY` is no strobe in `ST_IDLE`. The state stays `ST_IDLE`.

Writes take their data on the edge of the command. Read data is registered. It is presented only while the output enable is low, and it is held back for one clock when a read opens straight out of `ST_IDLE`.

Top module: `sync_burst_sram`

## Requirements
- R1: An access starts at an edge where `adsc_n` is low, or `adsp_n` is low, and the part is selected (`ce1_n`=0, `ce2`=1, `ce3_n`=0). The access uses the full address on `addr`, and `addr[1:0]` loads the burst counter.
- R2: While `ce1_n` is sampled high, a low `adsp_n` is ignored. The cycle behaves as if no strobe were present: from idle nothing happens, and inside a burst the burst continues.
- R3: A strobe at an edge where the part is not selected ends any burst and performs no access. After that edge `dq_oe` is 0. It stays 0 through later cycles without a strobe.
- R4: With no strobe and `adv_n` low inside a burst, the counter increments and the next word is accessed. The counter wraps 3 to 0 inside the aligned group, and the upper address bits do not change.
- R5: With no strobe and `adv_n` high inside a burst, the same word is accessed again.
- R6: When `gw_n` is low on an access, every lane is written from `wdata`, whatever `bwe_n` and `bw_n` hold.
- R7: When `gw_n` is high and `bwe_n` is low, the access is a write. Lane i (bits 9i+8 down to 9i) is written exactly when `bw_n[i]` is 0, and the other lanes keep their contents.
- R8: When `gw_n` and `bwe_n` are both high, the access is a read and `bw_n` is ignored. Its word appears on `dq_out` after the same edge.
- R9: While `oe_n` is high, `dq_oe` is 0 and `dq_out` is 0, with no clock needed.
- R10: A read that starts from the idle state is not presented during the clock that follows its edge. It is presented from the next access on.
- R11: After reset the controller is idle and `dq_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Word address, captured on a start |
| ce1_n | input | 1 | Chip enable 1, active low; also gates `adsp_n` |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3_n | input | 1 | Chip enable 3, active low |
| adsp_n | input | 1 | Processor-side address strobe, active low |
| adsc_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Whole-word write, active low |
| bwe_n | input | 1 | Lane write enable, active low |
| bw_n | input | LANES | Per-lane write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | LANES*LANE_W | Write data |
| dq_out | output | LANES*LANE_W | Read data, zero when released |
| dq_oe | output | 1 | High while read data is driven |

## Verification
The riskiest overlaps are a strobe and a burst step landing on the same edge, and output masking landing on a cycle with an access. In the bench, `adsp_n` is pulled low with `ce1_n` high in the middle of a read burst. The scoreboard then expects the held word, not a restart at the new address. A read is also opened in the cycle right after a deselect. The bench expects one released clock, followed by data on the next advance, while `oe_n` is toggled on a held cycle to separate the asynchronous release from the state machine.

// File: rtl/sram_burst_pkg.sv
package sram_burst_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } bst_t;

    localparam int BURST_BITS = 2;

endpackage

// File: rtl/sram_burst_ctr.sv
module sram_burst_ctr #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic              adv,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [1:0]        cnt
);
    localparam int UP_W = ADDR_W - sram_burst_pkg::BURST_BITS;

    logic [UP_W-1:0] up_q;
    logic [1:0]      cnt_q;

    // Linear counter confined to the aligned four-word group
    always_comb begin
        if (load)
            acc_addr = addr_in;
        else if (adv)
            acc_addr = {up_q, cnt_q + 2'd1};
        else
            acc_addr = {up_q, cnt_q};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_q  <= '0;
            cnt_q <= '0;
        end else if (load || step) begin
            {up_q, cnt_q} <= acc_addr;
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/sram_lane_decode.sv
module sram_lane_decode #(
    parameter int LANES = 4
) (
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bw_n,
    output logic [LANES-1:0] lane_we
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_we[i] = !gw_n || (!bwe_n && !bw_n[i]);
    end
endmodule

// File: rtl/sram_array.sv
module sram_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic [ADDR_W-1:0]       acc_addr,
    input  logic                    wr,
    input  logic                    rd,
    input  logic [LANES-1:0]        lane_we,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (wr && lane_we[i])
                mem[acc_addr] <= wdata[i*LANE_W +: LANE_W];
            if (rd)
                rd_q <= mem[acc_addr];
        end

        assign rdata[i*LANE_W +: LANE_W] = rd_q;
    end
endmodule

// File: rtl/sram_burst_ctrl.sv
module sram_burst_ctrl
    import sram_burst_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ce1_n,
    input  logic ce2,
    input  logic ce3_n,
    input  logic adsp_n,
    input  logic adsc_n,
    input  logic gw_n,
    input  logic bwe_n,
    input  logic oe_n,
    output logic load,
    output logic step,
    output logic rd,
    output logic wr,
    output logic drive,
    output bst_t st
);
    bst_t st_q, st_d;
    logic mask_q, mask_d;
    logic sel, strobe, desel, acc, is_wr;

    always_comb begin
        sel    = !ce1_n && ce2 && !ce3_n;
        strobe = !adsc_n || (!adsp_n && !ce1_n);
        is_wr  = !gw_n || !bwe_n;
        load   = strobe && sel;
        desel  = strobe && !sel;
        step   = !strobe && (st_q != ST_IDLE);
        acc    = load || step;
        st_d   = st_q;
        mask_d = 1'b0;
        unique case (1'b1)
            desel:   st_d = ST_IDLE;
            acc: begin
                st_d   = is_wr ? ST_WRITE : ST_READ;
                mask_d = !is_wr && (st_q == ST_IDLE);
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            mask_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            mask_q <= mask_d;
        end
    end

    always_comb begin
        rd    = acc && !is_wr;
        wr    = acc && is_wr;
        drive = !oe_n && (st_q == ST_READ) && !mask_q;
        st    = st_q;
    end

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
    import sram_burst_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    ce1_n,
    input  logic                    ce2,
    input  logic                    ce3_n,
    input  logic                    adsp_n,
    input  logic                    adsc_n,
    input  logic                    adv_n,
    input  logic                    gw_n,
    input  logic                    bwe_n,
    input  logic [LANES-1:0]        bw_n,
    input  logic                    oe_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] dq_out,
    output logic                    dq_oe
);
    localparam int W = LANES * LANE_W;

    logic              ld, stp, rd, wr, drive;
    bst_t              st;
    logic [ADDR_W-1:0] acc_addr;
    logic [1:0]        cnt_q;
    logic [LANES-1:0]  lane_we;
    logic [W-1:0]      rdata;

    sram_burst_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
        .adsp_n(adsp_n), .adsc_n(adsc_n), .gw_n(gw_n), .bwe_n(bwe_n),
        .oe_n(oe_n), .load(ld), .step(stp), .rd(rd), .wr(wr),
        .drive(drive), .st(st)
    );

    sram_burst_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .load(ld), .step(stp), .adv(!adv_n),
        .addr_in(addr), .acc_addr(acc_addr), .cnt(cnt_q)
    );

    sram_lane_decode #(.LANES(LANES)) u_dec (
        .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .lane_we(lane_we)
    );

    sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
        .clk(clk), .acc_addr(acc_addr), .wr(wr), .rd(rd),
        .lane_we(lane_we), .wdata(wdata), .rdata(rdata)
    );

    assign dq_oe  = drive;
    assign dq_out = drive ? rdata : '0;

endmodule

// File: rtl/sync_burst_sram_chk.sv
module sync_burst_sram_chk
    import sram_burst_pkg::*;
#(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ce1_n,
    input logic             ce2,
    input logic             ce3_n,
    input logic             adsc_n,
    input logic             adv_n,
    input logic             gw_n,
    input logic             bwe_n,
    input logic             oe_n,
    input logic             dq_oe,
    input bst_t             st,
    input logic             ld,
    input logic             stp,
    input logic [1:0]       cnt_q,
    input logic [LANES-1:0] lane_we
);
    logic sel;
    assign sel = !ce1_n && ce2 && !ce3_n;

    AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) oe_n |-> !dq_oe); // R9
    AST_DESEL_ENDS: assert property (@(posedge clk) disable iff (!rst_n) (!adsc_n && !sel) |=> (!dq_oe && st == ST_IDLE)); // R3
    AST_FIRST_MASK: assert property (@(posedge clk) disable iff (!rst_n) (st == ST_IDLE && ld && gw_n && bwe_n) |=> !dq_oe); // R10
    AST_BURST_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (stp && !adv_n && cnt_q == 2'd3) |=> cnt_q == 2'd0); // R4
    AST_BURST_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (stp && adv_n) |=> $stable(cnt_q)); // R5
    AST_GW_ALL: assert property (@(posedge clk) disable iff (!rst_n) !gw_n |-> (lane_we == {LANES{1'b1}})); // R6
    AST_READ_NO_LANE: assert property (@(posedge clk) disable iff (!rst_n) (gw_n && bwe_n) |-> (lane_we == '0)); // R8
endmodule

bind sync_burst_sram sync_burst_sram_chk #(.LANES(LANES)) u_chk (
    .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .adsc_n(adsc_n), .adv_n(adv_n), .gw_n(gw_n), .bwe_n(bwe_n),
    .oe_n(oe_n), .dq_oe(dq_oe), .st(st), .ld(ld), .stp(stp),
    .cnt_q(cnt_q), .lane_we(lane_we)
);

// File: tb/tb_sync_burst_sram.sv
`timescale 1ns/1ps
module tb_sync_burst_sram;
    localparam int AW = 6;
    localparam int NL = 4;
    localparam int LW = 9;
    localparam int W  = NL * LW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic ce1_n = 1'b0, ce2 = 1'b1, ce3_n = 1'b0;
    logic adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1;
    logic gw_n = 1'b1, bwe_n = 1'b1, oe_n = 1'b0;
    logic [NL-1:0] bw_n = '1;
    logic [W-1:0]  wdata = '0;
    logic [W-1:0]  dq_out;
    logic          dq_oe;

    // staged values applied at the next falling edge
    logic [AW-1:0] s_addr;
    logic s_ce1_n, s_ce2, s_ce3_n, s_adsp_n, s_adsc_n, s_adv_n, s_gw_n, s_bwe_n, s_oe_n;
    logic [NL-1:0] s_bw_n;
    logic [W-1:0]  s_wdata;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic         oe;
        logic [W-1:0] d;
        string        tag;
    } exp_t;
    exp_t sb[$];

    // reference state from the requirements
    logic [W-1:0]    bm [1<<AW];
    int              bst = 0;
    logic [AW-3:0]   bup = '0;
    logic [1:0]      bcnt = '0;
    logic [W-1:0]    brd = '0;
    logic            bmask = 1'b0;

    always #4 clk = !clk;

    sync_burst_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce1_n(ce1_n), .ce2(ce2),
        .ce3_n(ce3_n), .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
        .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n), .wdata(wdata),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    task automatic neutral();
        s_addr = '0; s_ce1_n = 1'b0; s_ce2 = 1'b1; s_ce3_n = 1'b0;
        s_adsp_n = 1'b1; s_adsc_n = 1'b1; s_adv_n = 1'b1;
        s_gw_n = 1'b1; s_bwe_n = 1'b1; s_oe_n = 1'b0; s_bw_n = '1; s_wdata = '0;
    endtask

    task automatic compare(input logic e_oe, input logic [W-1:0] e_d, input string tag);
        checks++;
        if (dq_oe !== e_oe || dq_out !== e_d) begin
            errors++;
            $display("FAIL %s: dq_oe=%0b dq_out=%h expected dq_oe=%0b dq_out=%h",
                     tag, dq_oe, dq_out, e_oe, e_d);
        end
    endtask

    // driver: apply staged inputs, then predict the state after the edge
    task automatic step(input string tag);
        logic sel, strobe, ld, acc, isw;
        logic [AW-1:0] a;
        exp_t e;
        @(negedge clk);
        addr = s_addr; ce1_n = s_ce1_n; ce2 = s_ce2; ce3_n = s_ce3_n;
        adsp_n = s_adsp_n; adsc_n = s_adsc_n; adv_n = s_adv_n;
        gw_n = s_gw_n; bwe_n = s_bwe_n; oe_n = s_oe_n; bw_n = s_bw_n; wdata = s_wdata;
        @(posedge clk);
        sel    = !ce1_n && ce2 && !ce3_n;
        strobe = !adsc_n || (!adsp_n && !ce1_n);
        ld     = strobe && sel;
        acc    = ld || (!strobe && bst != 0);
        isw    = !gw_n || !bwe_n;
        bmask  = 1'b0;
        if (strobe && !sel) begin
            bst = 0;
        end else if (acc) begin
            a = ld ? addr : {bup, (adv_n ? bcnt : bcnt + 2'd1)};
            {bup, bcnt} = a;
            if (isw) begin
                for (int i = 0; i < NL; i++)
                    if (!gw_n || !bw_n[i]) bm[a][i*LW +: LW] = wdata[i*LW +: LW];
                bst = 2;
            end else begin
                brd   = bm[a];
                bmask = (bst == 0);
                bst   = 1;
            end
        end
        e.oe  = !oe_n && bst == 1 && !bmask;
        e.d   = e.oe ? brd : '0;
        e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor: compare after the edge has settled
    initial begin
        forever begin
            exp_t e;
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                e = sb.pop_front();
                compare(e.oe, e.d, e.tag);
            end
        end
    end

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    localparam logic [W-1:0] W0 = 36'h1_2345_6789;
    localparam logic [W-1:0] W1 = 36'hA_BCDE_F012;
    localparam logic [W-1:0] W2 = 36'h5_5AA5_5AA5;
    localparam logic [W-1:0] W3 = 36'hF_0F0F_0F0F;

    initial begin
        neutral();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1 compare(1'b0, '0, "R11 reset state");

        neutral(); step("R11 idle stays released");
        neutral(); s_adsp_n = 1'b0; s_ce1_n = 1'b1; s_addr = 6'd5; step("R2 blocked strobe from idle");

        // four-word write burst from address 8
        neutral(); s_adsc_n = 1'b0; s_gw_n = 1'b0; s_addr = 6'd8; s_wdata = W0; step("R6 write start");
        neutral(); s_adv_n = 1'b0; s_gw_n = 1'b0; s_wdata = W1; step("R4 write step");
        neutral(); s_adv_n = 1'b0; s_gw_n = 1'b0; s_wdata = W2; step("R4 write step");
        neutral(); s_adv_n = 1'b0; s_gw_n = 1'b0; s_wdata = W3; step("R4 write step");

        neutral(); s_adsc_n = 1'b0; s_ce2 = 1'b0; step("R3 deselect");
        neutral(); s_adsp_n = 1'b0; s_addr = 6'd10; step("R10 first read masked");
        neutral(); s_adv_n = 1'b0; step("R4 read advance");
        neutral(); s_adv_n = 1'b0; step("R4 read wrap");
        neutral(); step("R5 hold address");
        neutral(); s_adsp_n = 1'b0; s_ce1_n = 1'b1; s_addr = 6'd33; step("R2 blocked strobe in burst");
        neutral(); s_oe_n = 1'b1; step("R9 output released");
        neutral(); s_adv_n = 1'b0; step("R4 read after release");

        // lane writes and whole-word override
        neutral(); s_adsc_n = 1'b0; s_addr = 6'd9; s_bwe_n = 1'b0; s_bw_n = 4'b1010;
        s_wdata = 36'h7_7777_7777; step("R7 lane write");
        neutral(); s_adsc_n = 1'b0; s_addr = 6'd20; s_gw_n = 1'b0; s_bwe_n = 1'b1; s_bw_n = 4'b1111;
        s_wdata = W2; step("R6 whole-word write");
        neutral(); s_adsc_n = 1'b0; s_addr = 6'd21; s_gw_n = 1'b0; s_bwe_n = 1'b0; s_bw_n = 4'b0111;
        s_wdata = W1; step("R6 override of lane selects");
        neutral(); s_adsc_n = 1'b0; s_addr = 6'd9; step("R7 read lane-written word");
        neutral(); s_adsc_n = 1'b0; s_addr = 6'd20; step("R6 read whole word");
        neutral(); s_adsc_n = 1'b0; s_addr = 6'd21; step("R6 read overridden word");
        neutral(); s_adsc_n = 1'b0; s_addr = 6'd11; s_bw_n = 4'b0000; step("R8 read ignores lane selects");
        neutral(); s_adsc_n = 1'b0; s_addr = 6'd11; step("R8 word unchanged");

        neutral(); s_adsc_n = 1'b0; s_ce3_n = 1'b1; step("R3 deselect by enable 3");
        neutral(); s_adv_n = 1'b0; step("R3 no access after deselect");
        neutral(); s_adsc_n = 1'b0; s_ce1_n = 1'b1; s_addr = 6'd8; step("R1 enable 1 high blocks start");
        neutral(); s_adsc_n = 1'b0; s_addr = 6'd8; step("R1 start from idle masked");
        neutral(); s_adv_n = 1'b0; step("R1 burst after start");

        neutral();
        repeat (3) @(posedge clk);
        #3;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule